// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the outcomes of the most recent resolved branches, one bit each. It also keeps a table of two-bit saturating counters. The table slot for a branch is found by XORing that outcome history with the low address bits of the branch. Because of this hash, one branch can use different counters depending on the path that led to it.

The fetch side presents the address bits and gets back a taken/not-taken guess at once, combinationally. It also gets back the table index that produced the guess. When the branch resolves, the pipeline returns that captured index together with the real outcome. The counter at that index is trained, and the outcome is shifted into the history. Training through the returned index means that history movement between predict and resolve cannot send the update to the wrong counter.

Top module: `gshare_dir_pred`

## Requirements
- R1: After reset the history register reads all zeros and every counter holds 2'b10 (weakly taken), so every lookup predicts taken.
- R2: On a cycle with `tr_valid` high, the history becomes `{hist[HIST_W-2:0], tr_taken}` on the next clock: the newest outcome enters at bit 0, 1 meaning taken, and the oldest bit is dropped. With `tr_valid` low the history is unchanged.
- R3: `lk_idx` equals `hist ^ lk_pc_bits`, where `lk_pc_bits` carries branch address bits [9:2] for the default width.
- R4: `lk_taken` is 1 when the counter at `lk_idx` is 2'b11 or 2'b10, and 0 when it is 2'b01 or 2'b00.
- R5: A taken outcome increments the trained counter and a not-taken outcome decrements it. The counter saturates at 2'b11 and at 2'b00.
- R6: A counter in a strong state needs two consecutive opposite outcomes before its prediction flips.
- R7: An update changes only the counter at `tr_idx`. No counter changes while `tr_valid` is low.
- R8: A lookup in the same cycle as an update reads the state from before that update. The update is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc_bits | input | HIST_W | Branch address bits used for lookup (PC[9:2] by default) |
| lk_idx | output | HIST_W | Table index used for this lookup, to be returned on resolve |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| tr_valid | input | 1 | A resolved branch is being reported |
| tr_taken | input | 1 | Actual outcome of the resolved branch |
| tr_idx | input | HIST_W | Index captured at prediction time |
| hist | output | HIST_W | Global outcome history, bit 0 newest |

## Verification
Lookups are combinational, so `lk_idx` and `lk_taken` are checked in the same cycle, a short delay after inputs change at the falling edge and before the next rising edge. Training and history shifting take effect at the rising edge that samples `tr_valid`. The bench therefore updates its reference model only after that edge, and the next cycle's lookup and `hist` are compared against the new state. A lookup that targets the index being trained is compared against the pre-update counter, which covers the same-cycle ordering.

// File: rtl/gshare_dir_pred.sv
module gshare_dir_pred #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] lk_pc_bits,
  output logic [HIST_W-1:0] lk_idx,
  output logic              lk_taken,
  input  logic              tr_valid,
  input  logic              tr_taken,
  input  logic [HIST_W-1:0] tr_idx,
  output logic [HIST_W-1:0] hist
);
  localparam int ENTRIES = 1 << HIST_W;

  logic [ENTRIES-1:0][1:0] pht;
  logic [1:0] cur, nxt;

  assign lk_idx   = hist ^ lk_pc_bits;
  assign lk_taken = pht[lk_idx][1];
  assign cur      = pht[tr_idx];

  always_comb begin
    if (tr_taken) nxt = (cur == 2'b11) ? cur : cur + 2'b01;
    else          nxt = (cur == 2'b00) ? cur : cur - 2'b01;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      pht  <= {ENTRIES{2'b10}};
    end else if (tr_valid) begin
      pht[tr_idx] <= nxt;
      hist        <= {hist[HIST_W-2:0], tr_taken};
    end
  end

  p_hist_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tr_valid |=> hist == {$past(hist[HIST_W-2:0]), $past(tr_taken)});
  p_hist_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tr_valid |=> $stable(hist));
  p_table_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tr_valid |=> $stable(pht));
  p_sat_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_taken && pht[tr_idx] == 2'b11) |=> pht[$past(tr_idx)] == 2'b11);
  p_sat_bot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && !tr_taken && pht[tr_idx] == 2'b00) |=> pht[$past(tr_idx)] == 2'b00);
  p_hyst_t_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && !tr_taken && pht[tr_idx] == 2'b11) |=> pht[$past(tr_idx)][1]);
  p_hyst_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_taken && pht[tr_idx] == 2'b00) |=> !pht[$past(tr_idx)][1]);
endmodule

// File: tb/gshare_dir_pred_tb.sv
module gshare_dir_pred_tb;
  localparam int W = 8;
  localparam int N = 1 << W;

  logic clk = 0, rst_n = 0;
  logic [W-1:0] lk_pc_bits = '0, tr_idx = '0;
  logic tr_valid = 0, tr_taken = 0;
  logic [W-1:0] lk_idx, hist;
  logic lk_taken;

  int n_chk = 0, n_fail = 0;
  logic [1:0] m_pht [N];
  logic [W-1:0] m_hist;

  always #10 clk = ~clk;

  gshare_dir_pred #(.HIST_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc_bits(lk_pc_bits), .lk_idx(lk_idx),
    .lk_taken(lk_taken), .tr_valid(tr_valid), .tr_taken(tr_taken),
    .tr_idx(tr_idx), .hist(hist));

  function automatic logic [W-1:0] f_idx(logic [W-1:0] h, logic [W-1:0] pc);
    return h ^ pc;
  endfunction

  function automatic logic [1:0] f_next(logic [1:0] c, logic t);
    if (t) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [W-1:0] pc, input logic v, input logic t,
                      input logic [W-1:0] ix, input string req);
    logic [W-1:0] ei;
    @(negedge clk);
    lk_pc_bits = pc; tr_valid = v; tr_taken = t; tr_idx = ix;
    #1;
    ei = f_idx(m_hist, pc);
    chk(lk_idx == ei, {req, " R3 idx"}, lk_idx, ei);
    chk(lk_taken == m_pht[ei][1], {req, " R4 taken"}, lk_taken, m_pht[ei][1]);
    chk(hist == m_hist, {req, " R2 hist"}, hist, m_hist);
    @(posedge clk); #1;
    if (v) begin
      m_pht[ix] = f_next(m_pht[ix], t);
      m_hist = {m_hist[W-2:0], t};
    end
  endtask

  task automatic probe(input logic [W-1:0] target, input logic exp, input string req);
    @(negedge clk);
    tr_valid = 0; lk_pc_bits = m_hist ^ target;
    #1;
    chk(lk_taken == exp, req, lk_taken, exp);
  endtask

  initial begin
    logic [W-1:0] cap;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) m_pht[i] = 2'b10;
    m_hist = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(hist == '0, "R1 hist zero", hist, 0);
    for (int i = 0; i < N; i++) begin
      @(negedge clk); lk_pc_bits = W'(i); #1;
      chk(lk_taken == 1'b1 && lk_idx == W'(i), "R1 weakly taken", lk_taken, 1);
    end

    // R6 hysteresis at 0x5A
    step(8'h00, 1, 1, 8'h5A, "R6"); step(8'h00, 1, 1, 8'h5A, "R6");
    step(8'h00, 1, 0, 8'h5A, "R6");
    probe(8'h5A, 1'b1, "R6 strong survives one miss");
    step(8'h00, 1, 0, 8'h5A, "R6");
    probe(8'h5A, 1'b0, "R6 flips after two misses");

    // R5 saturation low at 0x33
    for (int k = 0; k < 5; k++) step(8'h11, 1, 0, 8'h33, "R5");
    step(8'h11, 1, 1, 8'h33, "R5");
    probe(8'h33, 1'b0, "R5 saturated at 00 then one taken");
    for (int k = 0; k < 6; k++) step(8'h11, 1, 1, 8'h33, "R5");
    step(8'h11, 1, 0, 8'h33, "R5");
    probe(8'h33, 1'b1, "R5 saturated at 11 then one not taken");

    // R2 shift pattern T T T N then T -> low nibble 1101
    step(8'h00, 1, 1, 8'h01, "R2"); step(8'h00, 1, 1, 8'h02, "R2");
    step(8'h00, 1, 1, 8'h03, "R2"); step(8'h00, 1, 0, 8'h04, "R2");
    step(8'h00, 1, 1, 8'h05, "R2");
    @(negedge clk); tr_valid = 0; #1;
    chk(hist[3:0] == 4'b1101, "R2 shift order", hist[3:0], 4'b1101);
    step(8'h00, 0, 0, 8'h00, "R2 hold");
    step(8'h00, 0, 1, 8'h05, "R7 no update");

    // R8 same-cycle lookup reads old counter; R7 captured index
    cap = m_hist ^ 8'h77;
    step(8'h77, 1, 0, cap, "R8 same cycle");
    step(8'h77, 1, 0, cap, "R8 next");
    probe(cap, m_pht[cap][1], "R7 captured index trained");
    probe(cap ^ 8'h01, m_pht[cap ^ 8'h01][1], "R7 neighbour untouched");

    for (int k = 0; k < 4000; k++)
      step(W'($urandom), 1'($urandom % 4 != 0), 1'($urandom),
           W'($urandom), "R5/R7 random");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule